// File: doc/BRIEF.md
# Data TLB Lookup with Access Fault Checking

This block is a fully associative data-side translation buffer. A lookup presents a virtual page number, a context, an access class (ordinary load, store or non-faulting load) and the user/privileged mode. Every entry is compared at once. The matching entry's attribute bits then decide whether the access is allowed, whether it raises a data access exception, or whether it raises a data protection trap. The result carries the hit flag, the physical page, read and write permission, a fault flag, the trap class and a fault status word in which several fault-type bits can be set together.

Non-faulting loads form their own access class. They fault when they reach a page that has side effects. Every other access faults when it reaches a page reserved for non-faulting loads. These exception conditions, and the privilege check, are evaluated before the write-protection check and suppress it.

Entries are loaded through a plain fill port that writes one tag and translation pair per pulse. Lookup requests and results move over a valid/ready pair with a single registered result stage.

Top module: `dtlb_fault_chk`

## Requirements
- R1: A lookup hits an entry whose valid bit (bit 63 of the translation word) is set and whose virtual page number and context equal the request. The result reports the physical page taken from translation bits [PPN_LSB +: PPN_W] (bits 31:13 by default). The result is presented with `rsp_valid` on the cycle after the request is accepted.
- R2: When no entry matches, the result has hit low, no fault, trap code 2'b00, no read or write permission, and a physical page of zero.
- R3: An entry with the global bit (bit 0) set matches any request context.
- R4: A user access (`req_user`=1) to an entry with the privileged bit (bit 2) set gives trap code 2'b01 (data access exception) and sets status bit 2.
- R5: A non-faulting load (`req_acc`=2'b10) to an entry with the side-effect bit (bit 3) set gives trap code 2'b01 and sets status bit 3.
- R6: Any access class other than non-faulting load (2'b00 load, 2'b01 store, and the unused code 2'b11, which behaves as a load) to an entry with the non-fault-only bit (bit 60) set gives trap code 2'b01 and sets status bit 4.
- R7: All exception conditions present on one access are reported together in status bits 4:2.
- R8: A store to a hit entry whose writable bit (bit 1) is clear gives trap code 2'b10 (data protection) only when no data access exception condition is present. `rsp_fault` is high exactly when the trap code is not 2'b00.
- R9: Status bit 0 is set for stores and status bit 1 for non-faulting loads, on hits and misses alike.
- R10: On a hit without a fault, read permission is granted, and write permission is granted only when the writable bit is set. A faulting access gets neither permission.
- R11: When several entries match, the lowest index wins. An entry whose valid bit is clear never matches.
- R12: `req_ready` is high when no result is held or when `rsp_ready` is high. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A result with `rsp_valid` high and `rsp_ready` low stays unchanged until it is taken.
- R13: A `fill_en` pulse writes the tag and translation at `fill_idx`. Lookups accepted on later edges see the new entry. Reset clears every entry to invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Write one entry |
| fill_idx | input | IDX_W (6) | Entry index to write |
| fill_vpn | input | VPN_W (19) | Tag virtual page number |
| fill_ctx | input | CTX_W (13) | Tag context |
| fill_tte | input | 64 | Translation word with attribute bits |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_acc | input | 2 | Access class: 00 load, 01 store, 10 non-faulting load |
| req_user | input | 1 | Access made in user mode |
| req_vpn | input | VPN_W (19) | Virtual page number to translate |
| req_ctx | input | CTX_W (13) | Context of the access |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result taken |
| rsp_hit | output | 1 | An entry matched |
| rsp_ppn | output | PPN_W (19) | Physical page number |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_fault | output | 1 | Access faulted |
| rsp_trap | output | 2 | 00 none, 01 data access exception, 10 data protection |
| rsp_status | output | 5 | Fault status: 0 store, 1 non-faulting load, 2 privilege, 3 side-effect on non-faulting load, 4 non-fault-only page |

## Verification
The bench builds the block with its default parameters: 64 entries, 19-bit page numbers and a 13-bit context. With these values it fills both the first and the last index, and it places two matching tags far apart to exercise lowest-index priority. A reference model inside the bench predicts each result and covers every combination of the privileged, side-effect, non-fault-only and writable bits that the requirements name, including accumulated fault bits and the suppressed protection trap. One phase toggles `rsp_ready` so that results are held under back-pressure.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int TTE_W = 64;

  localparam int B_VALID = 63;
  localparam int B_NFO   = 60;
  localparam int B_USED  = 41;
  localparam int B_LOCK  = 6;
  localparam int B_SIDE  = 3;
  localparam int B_PRIV  = 2;
  localparam int B_WR    = 1;
  localparam int B_GLB   = 0;

  localparam int ST_W       = 5;
  localparam int ST_STORE   = 0;
  localparam int ST_NFLOAD  = 1;
  localparam int ST_FT_PRIV = 2;
  localparam int ST_FT_SIDE = 3;
  localparam int ST_FT_NFO  = 4;

  typedef enum logic [1:0] {
    ACC_LOAD   = 2'b00,
    ACC_STORE  = 2'b01,
    ACC_NFLOAD = 2'b10,
    ACC_RSVD   = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    TRAP_NONE = 2'b00,
    TRAP_DAE  = 2'b01,
    TRAP_PROT = 2'b10,
    TRAP_RSVD = 2'b11
  } trap_e;
endpackage

// File: rtl/dtlb_entry_store.sv
module dtlb_entry_store
  import dtlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 19,
  parameter int CTX_W   = 13,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [CTX_W-1:0]   fill_ctx,
  input  logic [TTE_W-1:0]   fill_tte,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [CTX_W-1:0]   lk_ctx,
  output logic [ENTRIES-1:0] match_vec,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [TTE_W-1:0]   rd_tte
);
  logic [VPN_W-1:0] vpn_q [ENTRIES];
  logic [CTX_W-1:0] ctx_q [ENTRIES];
  logic [TTE_W-1:0] tte_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i] <= '0;
        ctx_q[i] <= '0;
        tte_q[i] <= '0;
      end
    end else if (fill_en) begin
      vpn_q[fill_idx] <= fill_vpn;
      ctx_q[fill_idx] <= fill_ctx;
      tte_q[fill_idx] <= fill_tte;
    end
  end

  // one comparator per entry, all evaluated in parallel
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic vpn_eq;
    logic ctx_ok;
    assign vpn_eq       = (vpn_q[g] == lk_vpn);
    assign ctx_ok       = tte_q[g][B_GLB] || (ctx_q[g] == lk_ctx);
    assign match_vec[g] = tte_q[g][B_VALID] && vpn_eq && ctx_ok;
  end

  assign rd_tte = tte_q[rd_idx];
endmodule

// File: rtl/dtlb_hit_select.sv
module dtlb_hit_select #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match_vec,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);
  // lowest matching index wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dtlb_perm_check.sv
module dtlb_perm_check
  import dtlb_pkg::*;
#(
  parameter int PPN_W   = 19,
  parameter int PPN_LSB = 13
) (
  input  logic             hit,
  input  logic [TTE_W-1:0] tte,
  input  logic [1:0]       acc,
  input  logic             user,
  output logic [PPN_W-1:0] ppn,
  output logic             rd_ok,
  output logic             wr_ok,
  output logic             fault,
  output logic [1:0]       trap,
  output logic [ST_W-1:0]  status
);
  logic is_store, is_nf;
  logic ft_priv, ft_side, ft_nfo, dae, prot;
  logic unused_tte;

  assign is_store = (acc_e'(acc) == ACC_STORE);
  assign is_nf    = (acc_e'(acc) == ACC_NFLOAD);

  // exception conditions, each with its own status bit
  assign ft_priv = hit && user && tte[B_PRIV];
  assign ft_side = hit && is_nf && tte[B_SIDE];
  assign ft_nfo  = hit && !is_nf && tte[B_NFO];
  assign dae     = ft_priv || ft_side || ft_nfo;

  // protection only when no exception condition is present
  assign prot = hit && !dae && is_store && !tte[B_WR];

  always_comb begin
    status              = '0;
    status[ST_STORE]    = is_store;
    status[ST_NFLOAD]   = is_nf;
    status[ST_FT_PRIV]  = ft_priv;
    status[ST_FT_SIDE]  = ft_side;
    status[ST_FT_NFO]   = ft_nfo;
    if (dae)       trap = TRAP_DAE;
    else if (prot) trap = TRAP_PROT;
    else           trap = TRAP_NONE;
  end

  assign fault = dae || prot;
  assign rd_ok = hit && !fault;
  assign wr_ok = rd_ok && tte[B_WR];
  assign ppn   = hit ? tte[PPN_LSB +: PPN_W] : '0;

  assign unused_tte = ^tte;
endmodule

// File: rtl/dtlb_fault_chk.sv
module dtlb_fault_chk
  import dtlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 19,
  parameter int CTX_W   = 13,
  parameter int PPN_W   = 19,
  parameter int PPN_LSB = 13,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [CTX_W-1:0]  fill_ctx,
  input  logic [63:0]       fill_tte,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_acc,
  input  logic              req_user,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [CTX_W-1:0]  req_ctx,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic              rsp_rd_ok,
  output logic              rsp_wr_ok,
  output logic              rsp_fault,
  output logic [1:0]        rsp_trap,
  output logic [4:0]        rsp_status
);
  logic [ENTRIES-1:0] match_vec;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [TTE_W-1:0]   hit_tte;
  logic [PPN_W-1:0]   c_ppn;
  logic               c_rd, c_wr, c_fault;
  logic [1:0]         c_trap;
  logic [ST_W-1:0]    c_status;

  dtlb_entry_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
    .fill_ctx(fill_ctx), .fill_tte(fill_tte),
    .lk_vpn(req_vpn), .lk_ctx(req_ctx),
    .match_vec(match_vec), .rd_idx(hit_idx), .rd_tte(hit_tte)
  );

  dtlb_hit_select #(.ENTRIES(ENTRIES)) u_sel (
    .match_vec(match_vec), .hit(hit), .hit_idx(hit_idx)
  );

  dtlb_perm_check #(.PPN_W(PPN_W), .PPN_LSB(PPN_LSB)) u_perm (
    .hit(hit), .tte(hit_tte), .acc(req_acc), .user(req_user),
    .ppn(c_ppn), .rd_ok(c_rd), .wr_ok(c_wr), .fault(c_fault),
    .trap(c_trap), .status(c_status)
  );

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_ppn    <= '0;
      rsp_rd_ok  <= 1'b0;
      rsp_wr_ok  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_trap   <= TRAP_NONE;
      rsp_status <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit    <= hit;
        rsp_ppn    <= c_ppn;
        rsp_rd_ok  <= c_rd;
        rsp_wr_ok  <= c_wr;
        rsp_fault  <= c_fault;
        rsp_trap   <= c_trap;
        rsp_status <= c_status;
      end
    end
  end
endmodule

// File: rtl/dtlb_fault_chk_sva.sv
module dtlb_fault_chk_sva #(
  parameter int PPN_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [PPN_W-1:0] rsp_ppn,
  input logic             rsp_rd_ok,
  input logic             rsp_wr_ok,
  input logic             rsp_fault,
  input logic [1:0]       rsp_trap,
  input logic [4:0]       rsp_status
);
  a_r2_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> !rsp_fault && rsp_trap == 2'b00 && !rsp_rd_ok && !rsp_wr_ok && rsp_ppn == '0);

  a_r8_fault_matches_trap: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault == (rsp_trap != 2'b00));

  a_r8_prot_only_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trap == 2'b10 |-> rsp_status[4:2] == 3'b000 && rsp_status[0]);

  a_r9_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(rsp_status[1:0]) <= 1);

  a_r10_fault_no_perm: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> !rsp_rd_ok && !rsp_wr_ok);

  a_r10_wr_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_wr_ok |-> rsp_rd_ok);

  a_r12_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid &&
      $stable({rsp_hit, rsp_ppn, rsp_rd_ok, rsp_wr_ok, rsp_fault, rsp_trap, rsp_status}));
endmodule

bind dtlb_fault_chk dtlb_fault_chk_sva #(.PPN_W(PPN_W)) chk_i (.*);

// File: tb/dtlb_fault_chk_tb_top.sv
module dtlb_fault_chk_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;
  localparam int IW = 6;
  localparam int VW = 19;
  localparam int CW = 13;
  localparam int PW = 19;
  localparam int PL = 13;

  typedef struct packed {
    logic          hit;
    logic [PW-1:0] ppn;
    logic          rd;
    logic          wr;
    logic          fault;
    logic [1:0]    trap;
    logic [4:0]    st;
  } res_t;

  logic clk = 0, rst_n = 0;
  logic fill_en = 0;
  logic [IW-1:0] fill_idx = '0;
  logic [VW-1:0] fill_vpn = '0;
  logic [CW-1:0] fill_ctx = '0;
  logic [63:0] fill_tte = '0;
  logic req_valid = 0, req_ready, req_user = 0;
  logic [1:0] req_acc = 0;
  logic [VW-1:0] req_vpn = '0;
  logic [CW-1:0] req_ctx = '0;
  logic rsp_valid, rsp_ready = 1, rsp_hit, rsp_rd_ok, rsp_wr_ok, rsp_fault;
  logic [PW-1:0] rsp_ppn;
  logic [1:0] rsp_trap;
  logic [4:0] rsp_status;

  int checks = 0, errors = 0, cyc = 0;
  bit bp_on = 0, done = 0;
  res_t exp_q[$];
  string tag_q[$];
  logic [VW-1:0] m_vpn [N];
  logic [CW-1:0] m_ctx [N];
  logic [63:0]   m_tte [N];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  dtlb_fault_chk dut_i (.*);

  function automatic logic [63:0] mk(bit v, bit nfo, bit side, bit priv, bit wr, bit glb, logic [PW-1:0] ppn);
    logic [63:0] t = '0;
    t[63] = v; t[60] = nfo; t[3] = side; t[2] = priv; t[1] = wr; t[0] = glb;
    t[41] = 1'b1; t[6] = 1'b1;
    t[PL +: PW] = ppn;
    return t;
  endfunction

  function automatic res_t model(logic [1:0] acc, bit user, logic [VW-1:0] vpn, logic [CW-1:0] ctx);
    res_t r = '0;
    int k = -1;
    bit st, nf, fp, fs, fn, wok;
    for (int i = N - 1; i >= 0; i--)
      if (m_tte[i][63] && m_vpn[i] == vpn && (m_tte[i][0] || m_ctx[i] == ctx)) k = i;
    st = (acc == 2'b01);
    nf = (acc == 2'b10);
    r.st[0] = st; r.st[1] = nf;
    if (k < 0) return r;
    r.hit = 1;
    r.ppn = m_tte[k][PL +: PW];
    wok = m_tte[k][1];
    fp = user && m_tte[k][2];
    fs = nf && m_tte[k][3];
    fn = !nf && m_tte[k][60];
    r.st[2] = fp; r.st[3] = fs; r.st[4] = fn;
    if (fp || fs || fn) r.trap = 2'b01;
    else if (st && !wok) r.trap = 2'b10;
    r.fault = (r.trap != 0);
    r.rd = !r.fault;
    r.wr = !r.fault && wok;
    return r;
  endfunction

  task automatic fill(int idx, logic [VW-1:0] vpn, logic [CW-1:0] ctx, logic [63:0] tte);
    @(negedge clk);
    fill_en = 1; fill_idx = IW'(idx); fill_vpn = vpn; fill_ctx = ctx; fill_tte = tte;
    @(posedge clk); #1;
    fill_en = 0;
    m_vpn[idx] = vpn; m_ctx[idx] = ctx; m_tte[idx] = tte;
  endtask

  task automatic lookup(logic [1:0] acc, bit user, logic [VW-1:0] vpn, logic [CW-1:0] ctx, string tag);
    @(negedge clk);
    req_valid = 1; req_acc = acc; req_user = user; req_vpn = vpn; req_ctx = ctx;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    exp_q.push_back(model(acc, user, vpn, ctx));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  // monitor: drives rsp_ready, compares results as they are taken
  res_t held;
  bit held_v = 0;
  always @(negedge clk) begin
    res_t act, e;
    string t;
    act = '{rsp_hit, rsp_ppn, rsp_rd_ok, rsp_wr_ok, rsp_fault, rsp_trap, rsp_status};
    if (held_v) begin
      checks++;
      if (!rsp_valid || act != held) begin
        errors++;
        $display("FAIL R12 held result changed: actual %h expected %h", act, held);
      end
    end
    rsp_ready = bp_on ? cyc[0] : 1'b1;
    held_v = rsp_valid && !rsp_ready;
    held = act;
    if (rsp_valid && rsp_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected result: actual %h expected none", act);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, act, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_vpn[i] = '0; m_ctx[i] = '0; m_tte[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #2;
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R12 reset state: actual valid=%b ready=%b expected 0 1", rsp_valid, req_ready);
    end
    lookup(2'b00, 0, 19'h100, 13'd5, "R13 empty after reset");

    fill(0,  19'h100, 13'd5, mk(1,0,0,0,1,0, 19'h0AAAA));
    fill(1,  19'h101, 13'd5, mk(1,0,0,1,1,0, 19'h00011));
    fill(2,  19'h102, 13'd5, mk(1,0,1,0,1,0, 19'h00022));
    fill(3,  19'h103, 13'd5, mk(1,1,0,0,0,0, 19'h00033));
    fill(4,  19'h104, 13'd5, mk(1,1,0,1,1,0, 19'h00044));
    fill(5,  19'h105, 13'd5, mk(1,0,0,0,0,0, 19'h00055));
    fill(6,  19'h106, 13'd9, mk(1,0,0,0,1,1, 19'h00066));
    fill(7,  19'h107, 13'd5, mk(1,1,1,0,0,0, 19'h00077));
    fill(8,  19'h108, 13'd5, mk(0,0,0,0,1,0, 19'h00088));
    fill(10, 19'h200, 13'd1, mk(1,0,0,0,1,0, 19'h12345));
    fill(20, 19'h200, 13'd1, mk(1,0,0,0,1,0, 19'h54321));
    fill(63, 19'h3FF, 13'd2, mk(1,0,0,0,1,0, 19'h7FFFF));

    lookup(2'b00, 0, 19'h100, 13'd5, "R1 load hit");
    lookup(2'b01, 1, 19'h100, 13'd5, "R10 store writable");
    lookup(2'b00, 0, 19'h100, 13'd6, "R2 ctx mismatch miss");
    lookup(2'b01, 0, 19'h1FF, 13'd5, "R9 store miss class bit");
    lookup(2'b10, 0, 19'h1FF, 13'd5, "R9 nf load miss class bit");
    lookup(2'b00, 0, 19'h106, 13'd3, "R3 global any ctx");
    lookup(2'b00, 1, 19'h101, 13'd5, "R4 user on priv page");
    lookup(2'b00, 0, 19'h101, 13'd5, "R4 priv mode on priv page");
    lookup(2'b10, 0, 19'h102, 13'd5, "R5 nf load side effect");
    lookup(2'b00, 0, 19'h102, 13'd5, "R5 load on side effect ok");
    lookup(2'b00, 0, 19'h103, 13'd5, "R6 load on nfo page");
    lookup(2'b10, 0, 19'h103, 13'd5, "R6 nf load on nfo page ok");
    lookup(2'b11, 0, 19'h103, 13'd5, "R6 reserved class on nfo");
    lookup(2'b01, 1, 19'h104, 13'd5, "R7 priv plus nfo");
    lookup(2'b01, 0, 19'h105, 13'd5, "R8 store read-only prot");
    lookup(2'b00, 0, 19'h105, 13'd5, "R10 load read-only");
    lookup(2'b01, 0, 19'h103, 13'd5, "R8 prot suppressed by nfo");
    lookup(2'b10, 1, 19'h107, 13'd5, "R7 nf side only");
    lookup(2'b01, 0, 19'h107, 13'd5, "R8 store nfo readonly");
    lookup(2'b00, 0, 19'h108, 13'd5, "R11 invalid entry miss");
    lookup(2'b00, 0, 19'h200, 13'd1, "R11 lowest index wins");
    lookup(2'b00, 0, 19'h3FF, 13'd2, "R1 last entry");

    bp_on = 1;
    for (int i = 0; i < 8; i++)
      lookup(2'(i % 3), i[0], 19'h100 + 19'(i), 13'd5, "R12 backpressure");
    repeat (4) @(posedge clk);
    bp_on = 0;

    fill(63, 19'h3FF, 13'd2, mk(1,0,0,0,1,0, 19'h01234));
    lookup(2'b00, 0, 19'h3FF, 13'd2, "R13 overwrite entry");
    fill(0, 19'h100, 13'd5, mk(0,0,0,0,1,0, 19'h0AAAA));
    lookup(2'b00, 0, 19'h100, 13'd5, "R13 invalidated entry");
    fill(10, 19'h200, 13'd1, mk(0,0,0,0,1,0, 19'h12345));
    lookup(2'b00, 0, 19'h200, 13'd1, "R11 next match after invalidate");

    for (int i = 0; i < 100 && exp_q.size() != 0; i++) @(posedge clk);
    repeat (3) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12 results missing: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule